// File: doc/BRIEF.md
# PPS Flip-Flop Phase Sampler

This block is a coarse phase detector for disciplining a 10 MHz oscillator to a one-pulse-per-second reference. A single flag is raised by the rising edge of the reference pulse and dropped by the next rising edge of the oscillator. Its length therefore equals the phase lag of the oscillator behind the pulse, within one oscillator period. A programmable delay after each reference edge, counted in ticks of a fast sampling clock, picks the moment at which the flag is read. One bit is taken per reference pulse.

The bits are summed over a window of 1000 pulses, and the total is presented together with a one-cycle strobe. An external loop filter steers the oscillator so that the total settles at half the window. A far-off oscillator can beat with the reference and give a half-window total with no real lock. For that case the block also checks whether the bit sequence repeats with a short period and reports it on a separate alias output. Both edge inputs are synchronised into the sampling-clock domain through equal-length chains, so the relative offset of the two edges is preserved in sampling ticks.

Top module: `ppsf_sampler_top`

## Requirements
- R1: A rising edge on `pps_i` sets the phase flag. A rising edge on `osc_i` clears it. Both edges take effect at the same synchroniser latency.
- R2: When a reference edge and an oscillator edge fall on the same sampling tick, the clear wins and the flag stays low.
- R3: The oscillator edge lags the reference edge by k ticks. With a delay setting d below TICKS (8), the sampled bit is 1 exactly when k is nonzero and d < k.
- R4: A delay setting of TICKS or more counts as 100 ns or longer. `dly_bad_o` goes high one cycle after such a setting is applied. While the setting is held, reference pulses add nothing to the window: no strobe occurs and `cnt_o` does not change.
- R5: After WINDOW (1000) sampled pulses, `cnt_vld_o` is high for exactly one sampling-clock cycle, and `cnt_o` carries the number of ones in that window. `cnt_o` holds its value until the next strobe.
- R6: The accumulation restarts empty after each strobe, so every window's count depends only on its own pulses.
- R7: `alias_o` is updated with each strobe. It is 1 when the window's bits satisfy bit[i] == bit[i-p] for every i, for some period p from 2 to 8, and the count is neither 0 nor WINDOW. Otherwise it is 0.
- R8: While reset is active and after it is released, `cnt_o` is 0 and `cnt_vld_o`, `alias_o` and `dly_bad_o` are 0 until a window completes or a bad delay is applied.
- R9: The count covers the full range: a window with no ones reports 0, and a window with all ones reports WINDOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp_i | input | 1 | Fast sampling clock, at least 8x the oscillator |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| pps_i | input | 1 | Reference pulse, rising edge sets the flag |
| osc_i | input | 1 | Oscillator output, rising edge clears the flag |
| dly_i | input | DLY_W (4) | Sampling delay after the reference edge, in sampling ticks |
| cnt_o | output | CNT_W (10) | Number of ones in the last completed window |
| cnt_vld_o | output | 1 | One-cycle strobe when a window completes |
| alias_o | output | 1 | Short-period pattern seen in the last window |
| dly_bad_o | output | 1 | Delay setting is one oscillator period or longer |

## Verification
The bench places the oscillator edge at chosen tick offsets relative to each reference pulse. It drives whole windows whose bit patterns it predicts on its own. It targets coincident edges, where a set-priority flag would give an all-ones window of 1000 instead of 0. It also targets a delay exactly equal to the lag, where an off-by-one comparison flips every bit. Pulses sent under an over-long delay must not advance the window, or the strobe would arrive early with the wrong count. Alternating and period-3 patterns must raise the alias output, while pseudo-random and constant windows must not. A detector that forgot the constant-pattern exclusion, or that kept history across windows, would mislabel those cases.

// File: rtl/ppsf_pkg.sv
package ppsf_pkg;

  // depth of the input synchronisers; equal for both edge inputs
  localparam int unsigned SYNC_STAGES = 2;

  // one sampled bit handed from the sampler to the window accumulator
  typedef struct packed {
    logic vld;
    logic bit_v;
  } smp_t;

endpackage

// File: rtl/ppsf_edge.sv
module ppsf_edge
  import ppsf_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [SYNC_STAGES:0] chain_q;
    logic [SYNC_STAGES:0] chain_d;

    always_comb begin
      chain_d = {chain_q[SYNC_STAGES-1:0], din[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign rise[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  end

endmodule

// File: rtl/ppsf_sampler.sv
module ppsf_sampler
  import ppsf_pkg::*;
#(
  parameter int unsigned TICKS = 8,
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             flag_o,
  output logic             dly_bad_o,
  output smp_t             smp_o
);

  localparam logic [DLY_W-1:0] LAST_TICK = DLY_W'(TICKS - 1);

  logic             flag_q,  flag_d;
  logic             armed_q, armed_d;
  logic [DLY_W-1:0] dcnt_q,  dcnt_d;
  logic             bad_q,   bad_d;
  smp_t             smp_q,   smp_d;
  logic             dly_ok;
  logic             hit;

  always_comb begin
    dly_ok = (dly_i <= LAST_TICK);
    hit    = armed_q && dly_ok && (dcnt_q == dly_i);

    // clear has priority over set
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
    else            flag_d = flag_q;

    armed_d = armed_q;
    dcnt_d  = dcnt_q;
    if (set_i) begin
      armed_d = 1'b1;
      dcnt_d  = '0;
    end else if (armed_q) begin
      dcnt_d = dcnt_q + 1'b1;
      if (hit || (dcnt_q == LAST_TICK)) armed_d = 1'b0;
    end

    smp_d.vld   = hit;
    smp_d.bit_v = flag_q;
    bad_d       = !dly_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      dcnt_q  <= '0;
      bad_q   <= 1'b0;
      smp_q   <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
      dcnt_q  <= dcnt_d;
      bad_q   <= bad_d;
      smp_q   <= smp_d;
    end
  end

  assign flag_o    = flag_q;
  assign dly_bad_o = bad_q;
  assign smp_o     = smp_q;

endmodule

// File: rtl/ppsf_window.sv
module ppsf_window
  import ppsf_pkg::*;
#(
  parameter int unsigned WINDOW = 1000,
  parameter int unsigned MAXP   = 8,
  parameter int unsigned CNT_W  = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  smp_t             smp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             vld_o,
  output logic             alias_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(WINDOW);
  localparam int unsigned      NPER     = MAXP - 1;

  logic [CNT_W-1:0] idx_q,  idx_d;
  logic [CNT_W-1:0] ones_q, ones_d;
  logic [MAXP-1:0]  hist_q, hist_d;
  logic [NPER-1:0]  per_q,  per_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic             vld_q,  vld_d;
  logic             alias_q, alias_d;
  logic [NPER-1:0]  mis;
  logic [NPER-1:0]  per_upd;
  logic [CNT_W-1:0] ones_inc;

  // one mismatch detector per candidate period p = 2..MAXP
  for (genvar p = 2; p <= MAXP; p++) begin : g_per
    assign mis[p-2] = (idx_q >= CNT_W'(p)) && (smp_i.bit_v != hist_q[p-1]);
  end

  always_comb begin
    ones_inc = ones_q + CNT_W'(smp_i.bit_v);
    per_upd  = per_q & ~mis;

    idx_d   = idx_q;
    ones_d  = ones_q;
    hist_d  = hist_q;
    per_d   = per_q;
    cnt_d   = cnt_q;
    alias_d = alias_q;
    vld_d   = 1'b0;

    if (smp_i.vld) begin
      if (idx_q == LAST_IDX) begin
        vld_d   = 1'b1;
        cnt_d   = ones_inc;
        alias_d = (|per_upd) && (ones_inc != '0) && (ones_inc != FULL);
        idx_d   = '0;
        ones_d  = '0;
        hist_d  = '0;
        per_d   = '1;
      end else begin
        idx_d  = idx_q + 1'b1;
        ones_d = ones_inc;
        hist_d = {hist_q[MAXP-2:0], smp_i.bit_v};
        per_d  = per_upd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ones_q  <= '0;
      hist_q  <= '0;
      per_q   <= '1;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      alias_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      ones_q  <= ones_d;
      hist_q  <= hist_d;
      per_q   <= per_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      alias_q <= alias_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign vld_o   = vld_q;
  assign alias_o = alias_q;

endmodule

// File: rtl/ppsf_sampler_top.sv
module ppsf_sampler_top
  import ppsf_pkg::*;
#(
  parameter int unsigned WINDOW = 1000,
  parameter int unsigned TICKS  = 8,
  parameter int unsigned MAXP   = 8,
  parameter int unsigned DLY_W  = 4,
  parameter int unsigned CNT_W  = $clog2(WINDOW + 1)
) (
  input  logic             clk_smp_i,
  input  logic             rst_n_i,
  input  logic             pps_i,
  input  logic             osc_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_vld_o,
  output logic             alias_o,
  output logic             dly_bad_o
);

  logic [1:0] rs_q;
  logic       rst_n_q;
  logic [1:0] rise;
  logic       pps_rise;
  logic       osc_rise;
  logic       flag;
  smp_t       smp;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_smp_i or negedge rst_n_i) begin
    if (!rst_n_i) rs_q <= 2'b00;
    else          rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_q = rs_q[1];

  ppsf_edge #(.N(2)) u_edge (
    .clk   (clk_smp_i),
    .rst_n (rst_n_q),
    .din   ({osc_i, pps_i}),
    .rise  (rise)
  );
  assign pps_rise = rise[0];
  assign osc_rise = rise[1];

  ppsf_sampler #(.TICKS(TICKS), .DLY_W(DLY_W)) u_smp (
    .clk       (clk_smp_i),
    .rst_n     (rst_n_q),
    .set_i     (pps_rise),
    .clr_i     (osc_rise),
    .dly_i     (dly_i),
    .flag_o    (flag),
    .dly_bad_o (dly_bad_o),
    .smp_o     (smp)
  );

  ppsf_window #(.WINDOW(WINDOW), .MAXP(MAXP), .CNT_W(CNT_W)) u_win (
    .clk     (clk_smp_i),
    .rst_n   (rst_n_q),
    .smp_i   (smp),
    .cnt_o   (cnt_o),
    .vld_o   (cnt_vld_o),
    .alias_o (alias_o)
  );

endmodule

// File: rtl/ppsf_chk.sv
module ppsf_chk #(
  parameter int unsigned WINDOW = 1000,
  parameter int unsigned TICKS  = 8,
  parameter int unsigned DLY_W  = 4,
  parameter int unsigned CNT_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             set_e,
  input logic             clr_e,
  input logic             flag,
  input logic [DLY_W-1:0] dly,
  input logic             dly_bad,
  input logic [CNT_W-1:0] cnt,
  input logic             vld,
  input logic             alias_f
);

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_e && !clr_e) |=> flag);

  // R2
  clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_e |=> !flag);

  // R4
  dly_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dly) >= TICKS) |=> dly_bad);

  // R5
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable(cnt));

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= WINDOW);

  // R7
  alias_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alias_f |-> ((cnt != '0) && (32'(cnt) != WINDOW)));

endmodule

bind ppsf_sampler_top ppsf_chk #(
  .WINDOW (WINDOW),
  .TICKS  (TICKS),
  .DLY_W  (DLY_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk_smp_i),
  .rst_n   (rst_n_q),
  .set_e   (pps_rise),
  .clr_e   (osc_rise),
  .flag    (flag),
  .dly     (dly_i),
  .dly_bad (dly_bad_o),
  .cnt     (cnt_o),
  .vld     (cnt_vld_o),
  .alias_f (alias_o)
);

// File: tb/ppsf_sampler_top_tb.sv
module ppsf_sampler_top_tb;

  localparam int CLK_PERIOD = 12;
  localparam int WIN        = 1000;
  localparam int TICKS      = 8;
  localparam int PULSE      = 16;
  localparam int LIMIT      = 190000;

  logic       clk;
  logic       rst_n;
  logic       pps;
  logic       osc;
  logic [3:0] dly;
  logic [9:0] cnt;
  logic       cnt_vld;
  logic       alias_f;
  logic       dly_bad;

  int n_chk;
  int n_fail;
  int strobes;
  int last_cnt;
  int last_alias;
  int ks [WIN];
  bit done;

  ppsf_sampler_top u_dut (
    .clk_smp_i (clk),
    .rst_n_i   (rst_n),
    .pps_i     (pps),
    .osc_i     (osc),
    .dly_i     (dly),
    .cnt_o     (cnt),
    .cnt_vld_o (cnt_vld),
    .alias_o   (alias_f),
    .dly_bad_o (dly_bad)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && cnt_vld) begin
      strobes    = strobes + 1;
      last_cnt   = int'(cnt);
      last_alias = int'(alias_f);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one reference pulse, oscillator edge k ticks after it
  task automatic pulse(input int k);
    for (int i = 0; i < PULSE; i++) begin
      @(negedge clk);
      pps = (i < 4);
      osc = (i >= k) && (i < k + 4);
    end
  endtask

  task automatic run_window(input string req, input int d);
    bit bits [WIN];
    int ones;
    int s0;
    bit any_per;
    int exp_alias;
    s0 = strobes;
    ones = 0;
    dly = 4'(d);
    for (int i = 0; i < WIN; i++) begin
      pulse(ks[i]);
      bits[i] = (ks[i] != 0) && (d < ks[i]);
      ones = ones + int'(bits[i]);
    end
    any_per = 1'b0;
    for (int p = 2; p <= 8; p++) begin
      bit ok;
      ok = 1'b1;
      for (int i = p; i < WIN; i++) if (bits[i] != bits[i-p]) ok = 1'b0;
      if (ok) any_per = 1'b1;
    end
    exp_alias = (any_per && ones != 0 && ones != WIN) ? 1 : 0;
    repeat (10) @(negedge clk);
    check({req, " strobe"}, strobes - s0, 1);
    check({req, " count"}, last_cnt, ones);
    check({req, " alias R7"}, last_alias, exp_alias);
    check({req, " held R5"}, int'(cnt), ones);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pps = 1'b0; osc = 1'b0; dly = 4'd4;
    repeat (5) @(negedge clk);
    check("R8 cnt in reset", int'(cnt), 0);
    check("R8 vld in reset", int'(cnt_vld), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 cnt after reset", int'(cnt), 0);
    check("R8 alias after reset", int'(alias_f), 0);
    check("R8 dly_bad after reset", int'(dly_bad), 0);
  endtask

  // alternating lag 2/6 with delay 4: 0101.. gives half window, period 2
  task automatic t_alternate();
    for (int i = 0; i < WIN; i++) ks[i] = (i % 2 == 0) ? 2 : 6;
    run_window("R3 R5 alternate", 4);
    check("R7 alternate alias set", last_alias, 1);
    check("R5 alternate half", last_cnt, 500);
  endtask

  // pseudo-random lags including k == delay boundary
  task automatic t_random();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < WIN; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ks[i] = int'(lf % 16'd9);
    end
    run_window("R3 R6 random", 4);
  endtask

  // coincident edges: clear wins, all zeros
  task automatic t_coincident();
    for (int i = 0; i < WIN; i++) ks[i] = 0;
    run_window("R2 R9 coincident", 0);
    check("R2 coincident zero", last_cnt, 0);
  endtask

  // maximum lag, maximum valid delay: all ones
  task automatic t_full();
    for (int i = 0; i < WIN; i++) ks[i] = 8;
    run_window("R1 R9 full", 7);
    check("R9 full window", last_cnt, WIN);
  endtask

  // delay of one full oscillator period is refused and pulses are dropped
  task automatic t_bad_delay();
    int s0;
    int c0;
    s0 = strobes;
    c0 = int'(cnt);
    dly = 4'(TICKS);
    repeat (3) @(negedge clk);
    check("R4 dly_bad raised", int'(dly_bad), 1);
    for (int i = 0; i < 300; i++) pulse(5);
    check("R4 no strobe while bad", strobes - s0, 0);
    check("R4 count unchanged while bad", int'(cnt), c0);
    dly = 4'd3;
    repeat (3) @(negedge clk);
    check("R4 dly_bad cleared", int'(dly_bad), 0);
    for (int i = 0; i < WIN; i++) ks[i] = (i % 3 == 0) ? 2 : 6;
    run_window("R4 R7 period3", 3);
    check("R4 period3 count", last_cnt, 666);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; strobes = 0; last_cnt = 0; last_alias = 0; done = 1'b0;
    t_reset();
    t_alternate();
    t_random();
    t_coincident();
    t_full();
    t_bad_delay();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule